// File: doc/BRIEF.md
# Auxiliary Operand Register Controller

This block owns a single hidden operand register beside a processor datapath. An explicit load instruction writes it, and it comes in two variants. Several unrelated instructions also overwrite it as a side effect, and each of these follows its own rule:
- a pseudo-random step stores its result;
- a lookup-RAM read stores the word it fetched;
- a filter readout stores the sine accumulator;
- a nibble CRC step shifts the register left;
- a coprocessor command clears it.

The controller takes the decoded instruction strobes, picks the winning update for each cycle and holds the result.

The register is also read as a plain operand by a bitwise-select operation. For that operation the block computes the merged value from a destination word and a source word. Each 1 bit of the register selects the source bit, and each 0 bit keeps the destination bit.

After an explicit load, the block raises an interrupt-inhibit pulse while the next instruction is accepted. This stops a service routine from disturbing the register before the companion instruction uses it. Lookup reads made on behalf of the bytecode engine pass their data elsewhere and leave the register alone.

Top module: `aux_opnd_ctrl`

## Requirements
- R1: While rst_ni is low, q_o is 0 and int_inhibit_o is 0. The "previous instruction was a load" state resets to false.
- R2: An accepted instruction with ld_i or ld2_i set loads ld_val_i into q_o after that clock edge. With no update event, q_o holds its value.
- R3: An accepted instruction with prng_i set loads prng_val_i into q_o.
- R4: A lookup read is issued by an accepted instruction with lut_rd_i=1 and lut_bc_i=0. It loads q_o from lut_data_i at the third rising edge, counting the issue edge as the first. lut_data_i is sampled in the cycle two cycles after the issue cycle.
- R5: A lookup read issued with lut_bc_i=1 never changes q_o.
- R6: An accepted instruction with crc_nib_i set shifts q_o left by 4 bits and fills the low bits with zeros.
- R7: An accepted instruction with cop_cmd_i set clears q_o to 0. If the previous accepted instruction was an explicit load, it leaves q_o unchanged instead.
- R8: An accepted instruction with acc_rd_i set loads acc_val_i into q_o.
- R9: sel_o equals (sel_src_i & q_o) | (sel_dst_i & ~q_o) at all times, using the current q_o.
- R10: int_inhibit_o is 1 exactly when instr_valid_i is 1 and the previous accepted instruction was an explicit load.
- R11: When several updates fall on the same edge, the highest-priority one wins. The order from highest to lowest is: explicit load, lookup return, pseudo-random, accumulator, coprocessor clear, CRC shift.
- R12: Strobes presented while instr_valid_i is 0 change neither q_o nor the previous-load state. A lookup return already in flight still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | An instruction is accepted this cycle |
| ld_i | input | 1 | Explicit load, first variant |
| ld2_i | input | 1 | Explicit load, second variant |
| ld_val_i | input | 32 | Value for the explicit load |
| prng_i | input | 1 | Pseudo-random step instruction |
| prng_val_i | input | 32 | Pseudo-random result |
| lut_rd_i | input | 1 | Lookup-RAM read issued |
| lut_bc_i | input | 1 | Lookup read belongs to the bytecode engine |
| lut_data_i | input | 32 | Lookup-RAM read data, valid on the return cycle |
| crc_nib_i | input | 1 | Nibble CRC step instruction |
| cop_cmd_i | input | 1 | Coprocessor start, divide, fraction or rotate command |
| acc_rd_i | input | 1 | Filter accumulator readout instruction |
| acc_val_i | input | 32 | Sine accumulator value |
| sel_dst_i | input | 32 | Destination word for bitwise select |
| sel_src_i | input | 32 | Source word for bitwise select |
| q_o | output | 32 | Current register value |
| sel_o | output | 32 | Bitwise-select result |
| int_inhibit_o | output | 1 | Interrupt inhibit for the instruction after a load |

## Verification
The hardest situation to reach is a lookup return landing on the same edge as another update, or a coprocessor command that directly follows a load. Both depend on instructions issued earlier, so they cannot be set up in a single cycle. The directed part of the stimulus issues a read and then places an explicit load or a pseudo-random step two cycles later. It also places load–command and load–load–command sequences, with idle cycles inside some of them. The random part keeps the strobe density high so that multi-event edges and read pipelines that overlap each other occur often. A bench model that tracks reads in flight checks every edge.

// File: rtl/aux_opnd_pkg.sv
package aux_opnd_pkg;
  typedef enum logic [2:0] {
    UPD_NONE, UPD_LOAD, UPD_LUT, UPD_PRNG, UPD_ACC, UPD_CLR, UPD_SHIFT
  } upd_sel_e;

  // update requests for one edge, already qualified
  typedef struct packed {
    logic load;
    logic lut;
    logic prng;
    logic acc;
    logic clr;
    logic shift;
  } upd_req_t;
endpackage

// File: rtl/aux_lut_track.sv
module aux_lut_track #(
  parameter int unsigned LAT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  output logic ret_o
);
  localparam int unsigned STAGES = LAT - 1;

  logic [STAGES-1:0] pipe_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[0] <= 1'b0;
        else         pipe_q[0] <= issue_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= 1'b0;
        else         pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign ret_o = pipe_q[STAGES-1];
endmodule

// File: rtl/aux_ld_guard.sv
module aux_ld_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic ld_i,
  output logic pend_o,
  output logic inhibit_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (valid_i) pend_q <= ld_i;
  end

  assign pend_o    = pend_q;
  assign inhibit_o = pend_q & valid_i;

  // R10
  inhibit_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ld_i) |=> (valid_i == inhibit_o));

  // R12
  idle_keeps_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i) |=> (pend_o == $past(pend_o)));
endmodule

// File: rtl/aux_q_update.sv
module aux_q_update
  import aux_opnd_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned SH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  upd_req_t      req_i,
  input  logic [DW-1:0] ld_val_i,
  input  logic [DW-1:0] lut_data_i,
  input  logic [DW-1:0] prng_i,
  input  logic [DW-1:0] acc_i,
  output logic [DW-1:0] q_o
);
  upd_sel_e      sel;
  logic [DW-1:0] q_q, q_d;

  // fixed priority: load, lookup return, prng, accumulator, clear, shift
  always_comb begin
    if      (req_i.load)  sel = UPD_LOAD;
    else if (req_i.lut)   sel = UPD_LUT;
    else if (req_i.prng)  sel = UPD_PRNG;
    else if (req_i.acc)   sel = UPD_ACC;
    else if (req_i.clr)   sel = UPD_CLR;
    else if (req_i.shift) sel = UPD_SHIFT;
    else                  sel = UPD_NONE;
  end

  always_comb begin
    unique case (sel)
      UPD_LOAD:  q_d = ld_val_i;
      UPD_LUT:   q_d = lut_data_i;
      UPD_PRNG:  q_d = prng_i;
      UPD_ACC:   q_d = acc_i;
      UPD_CLR:   q_d = '0;
      UPD_SHIFT: q_d = q_q << SH;
      default:   q_d = q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  // R2
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i.load |=> (q_o == $past(ld_val_i)));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> $stable(q_o));

  // R6
  shift_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == upd_req_t'{shift: 1'b1, default: 1'b0}) |=> (q_o == ($past(q_o) << SH)));

  // R7
  clear_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i.clr && !req_i.load && !req_i.lut && !req_i.prng && !req_i.acc) |=> (q_o == '0));

  // R4
  lut_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i.lut && !req_i.load) |=> (q_o == $past(lut_data_i)));
endmodule

// File: rtl/aux_bitsel.sv
module aux_bitsel #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] q_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] src_i,
  output logic [DW-1:0] res_o
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign res_o[b] = q_i[b] ? src_i[b] : dst_i[b];
  end
endmodule

// File: rtl/aux_opnd_ctrl.sv
module aux_opnd_ctrl
  import aux_opnd_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned LUT_LAT = 3,
  parameter int unsigned CRC_SH  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_valid_i,
  input  logic          ld_i,
  input  logic          ld2_i,
  input  logic [DW-1:0] ld_val_i,
  input  logic          prng_i,
  input  logic [DW-1:0] prng_val_i,
  input  logic          lut_rd_i,
  input  logic          lut_bc_i,
  input  logic [DW-1:0] lut_data_i,
  input  logic          crc_nib_i,
  input  logic          cop_cmd_i,
  input  logic          acc_rd_i,
  input  logic [DW-1:0] acc_val_i,
  input  logic [DW-1:0] sel_dst_i,
  input  logic [DW-1:0] sel_src_i,
  output logic [DW-1:0] q_o,
  output logic [DW-1:0] sel_o,
  output logic          int_inhibit_o
);
  logic     ld_any, lut_issue, lut_ret, ld_pend;
  upd_req_t req;

  assign ld_any    = ld_i | ld2_i;
  assign lut_issue = instr_valid_i & lut_rd_i & ~lut_bc_i;

  aux_lut_track #(.LAT(LUT_LAT)) i_lut_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (lut_issue),
    .ret_o   (lut_ret)
  );

  aux_ld_guard i_ld_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (instr_valid_i),
    .ld_i      (ld_any),
    .pend_o    (ld_pend),
    .inhibit_o (int_inhibit_o)
  );

  always_comb begin
    req.load  = instr_valid_i & ld_any;
    req.lut   = lut_ret;
    req.prng  = instr_valid_i & prng_i;
    req.acc   = instr_valid_i & acc_rd_i;
    req.clr   = instr_valid_i & cop_cmd_i & ~ld_pend;
    req.shift = instr_valid_i & crc_nib_i;
  end

  aux_q_update #(.DW(DW), .SH(CRC_SH)) i_q_update (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .ld_val_i   (ld_val_i),
    .lut_data_i (lut_data_i),
    .prng_i     (prng_val_i),
    .acc_i      (acc_val_i),
    .q_o        (q_o)
  );

  aux_bitsel #(.DW(DW)) i_bitsel (
    .q_i   (q_o),
    .dst_i (sel_dst_i),
    .src_i (sel_src_i),
    .res_o (sel_o)
  );

  // R7
  cop_after_load_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_inhibit_o && cop_cmd_i && !ld_any && !lut_ret && !prng_i && !acc_rd_i && !crc_nib_i)
      |=> $stable(q_o));

  // R12
  invalid_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!instr_valid_i && !lut_ret) |=> $stable(q_o));
endmodule

// File: tb/test_aux_opnd_ctrl.sv
`timescale 1ns/1ps
module test_aux_opnd_ctrl;
  localparam int DW = 32;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          instr_valid, ld, ld2, prng, lut_rd, lut_bc, crc_nib, cop_cmd, acc_rd;
  logic [DW-1:0] ld_val, prng_val, lut_data, acc_val, sel_dst, sel_src;
  logic [DW-1:0] q, sel;
  logic          inh;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0]  m_q = '0;
  logic           m_pend = 1'b0;
  logic [LAT-2:0] m_pipe = '0;

  always #4 clk = ~clk;

  aux_opnd_ctrl i_aux_opnd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid),
    .ld_i(ld), .ld2_i(ld2), .ld_val_i(ld_val),
    .prng_i(prng), .prng_val_i(prng_val),
    .lut_rd_i(lut_rd), .lut_bc_i(lut_bc), .lut_data_i(lut_data),
    .crc_nib_i(crc_nib), .cop_cmd_i(cop_cmd),
    .acc_rd_i(acc_rd), .acc_val_i(acc_val),
    .sel_dst_i(sel_dst), .sel_src_i(sel_src),
    .q_o(q), .sel_o(sel), .int_inhibit_o(inh)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_next(input logic [DW-1:0] cur, input logic pend,
                                               input logic ret);
    logic v = instr_valid;
    if (v && (ld || ld2))        return ld_val;
    if (ret)                     return lut_data;
    if (v && prng)               return prng_val;
    if (v && acc_rd)             return acc_val;
    if (v && cop_cmd && !pend)   return '0;
    if (v && crc_nib)            return cur << 4;
    return cur;
  endfunction

  task automatic idle();
    instr_valid = 0; ld = 0; ld2 = 0; prng = 0; lut_rd = 0; lut_bc = 0;
    crc_nib = 0; cop_cmd = 0; acc_rd = 0;
  endtask

  // inputs set at negedge by caller; checks comb outputs, then q after the edge
  task automatic step(input string tag);
    logic [DW-1:0] nq;
    logic npend;
    logic ret;
    #1;
    chk("R10 inhibit", {31'd0, inh}, {31'd0, m_pend & instr_valid});
    chk("R9 select", sel, (sel_src & m_q) | (sel_dst & ~m_q));
    ret   = m_pipe[LAT-2];
    nq    = model_next(m_q, m_pend, ret);
    npend = instr_valid ? (ld | ld2) : m_pend;
    @(posedge clk);
    m_q    = nq;
    m_pend = npend;
    m_pipe = {m_pipe[LAT-3:0], instr_valid & lut_rd & ~lut_bc};
    @(negedge clk);
    chk(tag, q, m_q);
    idle();
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0001));
    idle();
    ld_val = '0; prng_val = '0; lut_data = '0; acc_val = '0;
    sel_dst = 32'hFFFF_0000; sel_src = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk("R1 reset q", q, '0);
    chk("R1 reset inhibit", {31'd0, inh}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset q", q, '0);

    // explicit loads and persistence
    instr_valid = 1; ld = 1; ld_val = 32'hA5A5_0F0F; step("R2 load");
    step("R2 hold"); step("R2 hold");
    instr_valid = 1; ld2 = 1; ld_val = 32'h1234_5678; step("R2 load2");
    chk("R2 literal", q, 32'h1234_5678);
    instr_valid = 1; crc_nib = 1; step("R6 shift");
    chk("R6 literal", q, 32'h2345_6780);
    instr_valid = 1; prng = 1; prng_val = 32'hDEAD_BEEF; step("R3 prng");
    instr_valid = 1; acc_rd = 1; acc_val = 32'h0BAD_F00D; step("R8 acc");
    sel_dst = 32'h0F0F_0F0F; sel_src = 32'hF0F0_F0F0; step("R9 select path");

    // coprocessor command after load keeps, otherwise clears
    instr_valid = 1; ld = 1; ld_val = 32'h7777_1111; step("R2 load");
    instr_valid = 1; cop_cmd = 1; step("R7 cop after load keeps");
    chk("R7 literal keep", q, 32'h7777_1111);
    instr_valid = 1; cop_cmd = 1; step("R7 cop clears");
    chk("R7 literal clear", q, '0);
    // load, idle gap, then command: still immediately after the load
    instr_valid = 1; ld = 1; ld_val = 32'h4444_2222; step("R2 load");
    step("R12 gap");
    instr_valid = 1; cop_cmd = 1; step("R7 cop after gap keeps");
    // load, load, command
    instr_valid = 1; ld = 1; ld_val = 32'h1; step("R10 load");
    instr_valid = 1; ld2 = 1; ld_val = 32'h2; step("R10 load after load");
    instr_valid = 1; cop_cmd = 1; step("R7 keeps after second load");

    // lookup read, three-edge latency
    instr_valid = 1; lut_rd = 1; lut_data = 32'h0; step("R4 issue");
    lut_data = 32'h0; step("R4 wait");
    lut_data = 32'hCAFE_0123; step("R4 return");
    chk("R4 literal", q, 32'hCAFE_0123);
    // bytecode-owned read leaves register alone
    instr_valid = 1; lut_rd = 1; lut_bc = 1; step("R5 bc issue");
    lut_data = 32'h5555_AAAA; step("R5 wait"); step("R5 no return");
    chk("R5 literal", q, 32'hCAFE_0123);

    // strobes with no valid
    ld = 1; ld_val = 32'hFFFF_FFFF; prng = 1; cop_cmd = 1; crc_nib = 1; acc_rd = 1; lut_rd = 1;
    step("R12 invalid strobes");
    chk("R12 literal", q, 32'hCAFE_0123);

    // collisions
    instr_valid = 1; ld = 1; prng = 1; acc_rd = 1; cop_cmd = 1; crc_nib = 1;
    ld_val = 32'h0101_0101; step("R11 load beats all");
    instr_valid = 1; prng = 1; acc_rd = 1; cop_cmd = 1; crc_nib = 1;
    prng_val = 32'h0202_0202; step("R11 prng beats acc");
    instr_valid = 1; acc_rd = 1; cop_cmd = 1; crc_nib = 1;
    acc_val = 32'h0303_0303; step("R11 acc beats clear");
    instr_valid = 1; cop_cmd = 1; crc_nib = 1; step("R11 clear beats shift");
    instr_valid = 1; lut_rd = 1; step("R4 issue");
    step("R4 wait");
    instr_valid = 1; ld = 1; ld_val = 32'h9999_0000; lut_data = 32'h1111_EEEE;
    step("R11 load beats lut return");
    instr_valid = 1; lut_rd = 1; step("R4 issue");
    step("R4 wait");
    instr_valid = 1; prng = 1; prng_val = 32'h8888; lut_data = 32'h2222_DDDD;
    step("R11 lut return beats prng");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      instr_valid = ($urandom_range(3) != 0);
      ld       = ($urandom_range(5) == 0);
      ld2      = ($urandom_range(7) == 0);
      prng     = ($urandom_range(4) == 0);
      lut_rd   = ($urandom_range(3) == 0);
      lut_bc   = ($urandom_range(1) == 0);
      crc_nib  = ($urandom_range(3) == 0);
      cop_cmd  = ($urandom_range(3) == 0);
      acc_rd   = ($urandom_range(4) == 0);
      ld_val   = $urandom; prng_val = $urandom; lut_data = $urandom;
      acc_val  = $urandom; sel_dst  = $urandom; sel_src  = $urandom;
      step("R11 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule